// File: doc/BRIEF.md
# Keyed Configuration Item Streamer

This block is a small memory-mapped slave through which boot firmware reads configuration items. Each item has a 16-bit key. Firmware first writes a key into a selector register. It then pulls the item's bytes out of a 64-bit data register. Every data access moves an internal byte cursor forward by the access width. A run of narrow reads therefore returns exactly the same byte sequence as a run of wide reads.

The block holds four items:

- A 4-byte signature.
- A 4-byte interface revision word.
- An 8-byte read-only test pattern.
- A 16-byte writable scratch item. Data-register writes overwrite it from the cursor onward.

Reads past an item's end, and reads of unknown keys, return zero bytes. Writes that land nowhere valid are dropped.

The bus carries a request strobe, a write flag, a 4-bit byte address and a 2-bit size code. The size code is 0, 1, 2 or 3, for 1, 2, 4 or 8 bytes. The byte at the lowest address of an access travels in lane 0 (bits 7:0). Read data is returned one cycle after the request, qualified by a valid pulse.

Top module: `blobServer`

## Requirements
- R1: After reset, the selected key is 0x0000, the cursor is 0, read data is zero and the read-valid output is low. A read issued without any selector write therefore returns the signature.
- R2: A write at address 8 with size code 1 loads the key big-endian: wdata[7:0] is the high key byte and wdata[15:8] is the low key byte. The same write resets the cursor to 0.
- R3: A read at address 0 with size code s returns 2^s bytes. Lane k (bits 8k+7:8k) carries item byte cursor+k. Lanes at or above 2^s read zero. The data appears in the cycle after the request.
- R4: Each accepted data-register read or write advances the cursor by its width in bytes. The cursor saturates at 255.
- R5: Key 0x0000 is a 4-byte item holding bytes 0x51, 0x45, 0x4D, 0x55 in that order.
- R6: Key 0x0001 is a 4-byte item whose little-endian value is zero.
- R7: Key 0x0002 is an 8-byte read-only item whose byte i is 0xA0+i. Key 0x0003 is a 16-byte writable item that is all zero after reset.
- R8: A data write while key 0x0003 is selected stores wdata lane k at item byte cursor+k, for every lane below the access width that falls inside the item.
- R9: Item bytes at or beyond the item's length read as zero, and every byte of an unknown key reads as zero.
- R10: Data writes while key 0x0000, 0x0001, 0x0002 or an unknown key is selected change no item content. The cursor still advances as in R4.
- R11: An access at any address other than 0 or 8, or at address 8 with a size code other than 1, changes neither the key nor the cursor. If it is a read, it returns zero.
- R12: Every read request, whatever its address, raises read-valid for exactly the following cycle. Reads of the selector return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Access request, one cycle per access |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Byte address within the region |
| busSize | input | 2 | Access size code: 1, 2, 4 or 8 bytes |
| busWdata | input | 64 | Write data, lowest address in lane 0 |
| busRdata | output | 64 | Read data, valid with busRvalid |
| busRvalid | output | 1 | Read data valid, one cycle after a read |

## Verification
The hardest behaviour to reach from the ports is the cursor position within an item after a mix of widths, ignored accesses and writes. A wrong cursor shows up only in the bytes of a later read. The stimulus interleaves 1-, 2-, 4- and 8-byte reads within the same item, and inserts misaddressed and wrongly sized accesses in between. It then reads on and checks that the byte sequence continues where it left off. For the writable item, it writes in two different widths, reselects the item and reads back across the item's end, so the write placement, the cursor reset and the zero tail are all checked at once.

// File: rtl/blobSrvPkg.sv
package blobSrvPkg;
  localparam int ADDR_W = 4;
  localparam int KEY_W  = 16;
  localparam int DATA_W = 64;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = 8;
  localparam int NB_W   = $clog2(LANES) + 1;

  localparam logic [ADDR_W-1:0] DATA_ADDR = 4'd0;
  localparam logic [ADDR_W-1:0] SEL_ADDR  = 4'd8;

  localparam logic [KEY_W-1:0] KEY_SIG = 16'h0000;
  localparam logic [KEY_W-1:0] KEY_REV = 16'h0001;
  localparam logic [KEY_W-1:0] KEY_PAT = 16'h0002;
  localparam logic [KEY_W-1:0] KEY_RAM = 16'h0003;

  localparam logic [31:0] SIG_WORD = 32'h554D4551;
  localparam int SIG_LEN = 4;
  localparam int REV_LEN = 4;

  typedef struct packed {
    logic             selWr;
    logic             dataRd;
    logic             dataWr;
    logic [NB_W-1:0]  nBytes;
    logic [KEY_W-1:0] newKey;
  } strobeT;
endpackage

// File: rtl/blobCtrl.sv
module blobCtrl
  import blobSrvPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [15:0]       wdataLo,
  output strobeT            strb,
  output logic              rdValid
);
  logic dataHit, selHit;

  always_comb begin
    dataHit     = (addr == DATA_ADDR);
    selHit      = (addr == SEL_ADDR) && (size == 2'd1);
    strb.selWr  = req && we && selHit;
    strb.dataRd = req && !we && dataHit;
    strb.dataWr = req && we && dataHit;
    strb.nBytes = NB_W'(1) << size;
    strb.newKey = {wdataLo[7:0], wdataLo[15:8]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= req && !we;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selWr, strb.dataRd, strb.dataWr})); // R11
  AST_WIDTH_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataRd || strb.dataWr) |-> $countones(strb.nBytes) == 1); // R3
endmodule

// File: rtl/blobDatapath.sv
module blobDatapath
  import blobSrvPkg::*;
#(
  parameter int         RAM_BYTES = 16,
  parameter int         PAT_BYTES = 8,
  parameter logic [7:0] PAT_BASE  = 8'hA0
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [OFF_W-1:0] OFF_MAX = '1;

  logic [KEY_W-1:0] keyReg;
  logic [OFF_W-1:0] offReg;
  logic [7:0]       ram [RAM_BYTES];
  logic [DATA_W-1:0] rdNext;
  logic [OFF_W:0]   offSum;

  always_comb begin
    rdNext = '0;
    for (int k = 0; k < LANES; k++) begin
      logic [OFF_W:0] idx;
      logic [7:0]     b;
      idx = {1'b0, offReg} + (OFF_W+1)'(k);
      b   = 8'h00;
      unique case (keyReg)
        KEY_SIG: if (int'(idx) < SIG_LEN)   b = SIG_WORD[8*idx[1:0] +: 8];
        KEY_REV: b = 8'h00;
        KEY_PAT: if (int'(idx) < PAT_BYTES) b = 8'(PAT_BASE + idx[7:0]);
        KEY_RAM: if (int'(idx) < RAM_BYTES) b = ram[int'(idx)];
        default: b = 8'h00;
      endcase
      if (k < int'(strb.nBytes)) rdNext[8*k +: 8] = b;
    end
    offSum = {1'b0, offReg} + (OFF_W+1)'(strb.nBytes);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyReg <= KEY_SIG;
      offReg <= '0;
      rdata  <= '0;
    end else begin
      rdata <= strb.dataRd ? rdNext : '0;
      if (strb.selWr) begin
        keyReg <= strb.newKey;
        offReg <= '0;
      end else if (strb.dataRd || strb.dataWr) begin
        offReg <= offSum[OFF_W] ? OFF_MAX : offSum[OFF_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < RAM_BYTES; j++) ram[j] <= 8'h00;
    end else if (strb.dataWr && keyReg == KEY_RAM) begin
      for (int k = 0; k < LANES; k++) begin
        if (k < int'(strb.nBytes) && int'(offReg) + k < RAM_BYTES)
          ram[int'(offReg) + k] <= wdata[8*k +: 8];
      end
    end
  end

  AST_SEL_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    strb.selWr |=> (offReg == '0) && (keyReg == $past(strb.newKey))); // R2
  AST_CURSOR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.dataRd || strb.dataWr) && offReg < 8'd200)
      |=> offReg == $past(offReg) + OFF_W'($past(strb.nBytes))); // R4
  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.selWr |=> $stable(keyReg)); // R11
  AST_SIG_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataRd && keyReg == KEY_SIG && int'(offReg) >= SIG_LEN)
      |=> rdata == '0); // R9
  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (strb.selWr || strb.dataWr) |=> rdata == '0); // R12
endmodule

// File: rtl/blobServer.sv
module blobServer
  import blobSrvPkg::*;
#(
  parameter int         RAM_BYTES = 16,
  parameter int         PAT_BYTES = 8,
  parameter logic [7:0] PAT_BASE  = 8'hA0
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid
);
  strobeT strb;

  blobCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .req     (busReq),
    .we      (busWe),
    .addr    (busAddr),
    .size    (busSize),
    .wdataLo (busWdata[15:0]),
    .strb    (strb),
    .rdValid (busRvalid)
  );

  blobDatapath #(
    .RAM_BYTES (RAM_BYTES),
    .PAT_BYTES (PAT_BYTES),
    .PAT_BASE  (PAT_BASE)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wdata (busWdata),
    .rdata (busRdata)
  );
endmodule

// File: tb/blobServer_bench.sv
module blobServer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0;
  logic        busWe = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [1:0]  busSize = '0;
  logic [63:0] busWdata = '0;
  logic [63:0] busRdata;
  logic        busRvalid;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  int mKey = 0;
  int mOff = 0;
  logic [7:0] mRam [16];

  always #2.5 clk = ~clk;

  blobServer u_blobServer (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .busRvalid(busRvalid)
  );

  function automatic logic [7:0] refByte(int key, int idx);
    logic [7:0] sig [4];
    sig[0] = 8'h51; sig[1] = 8'h45; sig[2] = 8'h4D; sig[3] = 8'h55;
    if (key == 0 && idx < 4)  return sig[idx];
    if (key == 2 && idx < 8)  return 8'hA0 + 8'(idx);
    if (key == 3 && idx < 16) return mRam[idx];
    return 8'h00;
  endfunction

  task automatic check(string tag, logic [63:0] actD, logic [63:0] expD,
                       logic actV, logic expV);
    nCmp++;
    if (actD !== expD || actV !== expV) begin
      nBad++;
      $display("FAIL %s: rdata=%h valid=%b expected rdata=%h valid=%b",
               tag, actD, actV, expD, expV);
    end
  endtask

  task automatic step(bit r, bit w, int a, int s, logic [63:0] d, string tag);
    logic [63:0] expD;
    logic expV;
    int width;
    @(negedge clk);
    busReq = r; busWe = w; busAddr = 4'(a); busSize = 2'(s); busWdata = d;
    @(posedge clk);
    width = 1 << s;
    expV = r && !w;
    expD = '0;
    if (r && !w && a == 0)
      for (int k = 0; k < width; k++) expD[8*k +: 8] = refByte(mKey, mOff + k);
    if (r && w && a == 8 && s == 1) begin
      mKey = {d[7:0], d[15:8]};
      mOff = 0;
    end else if (r && a == 0) begin
      if (w && mKey == 3)
        for (int k = 0; k < width; k++)
          if (mOff + k < 16) mRam[mOff + k] = d[8*k +: 8];
      mOff = (mOff + width > 255) ? 255 : mOff + width;
    end
    #1;
    check(tag, busRdata, expD, busRvalid, expV);
    busReq = 1'b0;
  endtask

  task automatic sel(logic [15:0] key, string tag);
    step(1, 1, 8, 1, {48'h0, key[7:0], key[15:8]}, tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      nBad++;
      nCmp++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < 16; j++) mRam[j] = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset", busRdata, 64'h0, busRvalid, 1'b0);
    rstN = 1'b1;
    step(0, 0, 0, 0, 0, "R1 idle");
    // R1: default key is signature; byte reads then past end (R9)
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, "R1 R5 R9 bytewise sig");
    sel(16'h0000, "R2 select sig");
    step(1, 0, 0, 2, 0, "R5 R3 sig word");
    step(1, 0, 0, 3, 0, "R9 sig past end");
    sel(16'h0001, "R2 select rev");
    step(1, 0, 0, 2, 0, "R6 revision zero");
    // R2 big-endian: key 0x0002 is sent as wdata 0x0200
    sel(16'h0002, "R2 select pat");
    step(1, 0, 0, 3, 0, "R7 R3 pattern dword");
    sel(16'h0002, "R2 reselect restarts");
    step(1, 0, 0, 1, 0, "R4 half");
    step(1, 0, 0, 1, 0, "R4 half");
    step(1, 0, 0, 2, 0, "R4 word");
    step(1, 0, 0, 0, 0, "R9 pat end");
    // R10: writes to read-only items ignored
    sel(16'h0002, "R2 reselect");
    step(1, 1, 0, 3, 64'hDEADBEEF_CAFEF00D, "R10 write ro");
    sel(16'h0000, "R2 to sig");
    step(1, 1, 0, 2, 64'h11223344, "R10 write sig");
    sel(16'h0000, "R2 to sig");
    step(1, 0, 0, 2, 0, "R10 sig intact");
    sel(16'h0002, "R2 to pat");
    step(1, 0, 0, 3, 0, "R10 pat intact");
    // R8: writable scratch item
    sel(16'h0003, "R2 to ram");
    step(1, 0, 0, 3, 0, "R7 ram zero");
    sel(16'h0003, "R2 to ram");
    step(1, 1, 0, 3, 64'h8877665544332211, "R8 write dword");
    step(1, 1, 0, 1, 64'h0000_0000_0000_BBAA, "R8 write half");
    step(1, 1, 0, 3, 64'hF7F6F5F4F3F2F1F0, "R8 write across end");
    sel(16'h0003, "R2 to ram");
    step(1, 0, 0, 2, 0, "R8 read word");
    step(1, 0, 0, 2, 0, "R8 read word");
    step(1, 0, 0, 3, 0, "R8 read dword");
    step(1, 0, 0, 3, 0, "R9 ram past end");
    // R11: misaddressed / wrongly sized accesses
    sel(16'h0002, "R2 to pat");
    step(1, 0, 0, 0, 0, "R11 pre");
    step(1, 0, 4, 3, 0, "R11 read bad addr");
    step(1, 1, 4, 3, 64'hFF, "R11 write bad addr");
    step(1, 0, 0, 0, 0, "R11 cursor held");
    step(1, 1, 8, 2, 64'h0300, "R11 sel wrong size");
    step(1, 1, 9, 0, 64'h03, "R11 sel odd addr");
    step(1, 0, 0, 0, 0, "R11 key held");
    // R12: selector reads
    step(1, 0, 8, 1, 0, "R12 sel read zero");
    step(0, 0, 0, 0, 0, "R12 idle no valid");
    // R9 unknown key
    sel(16'h1234, "R2 unknown key");
    step(1, 1, 0, 3, 64'h0102030405060708, "R10 write unknown");
    sel(16'h1234, "R2 unknown key");
    step(1, 0, 0, 3, 0, "R9 unknown reads zero");
    // R4 saturation: 40 dword reads drive cursor past 255
    sel(16'h0003, "R2 to ram");
    for (int i = 0; i < 40; i++) step(1, 0, 0, 3, 0, "R4 saturate");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule